// File: doc/BRIEF.md
# Frame-Pattern Lane Alignment Controller

This controller brings the serial lanes of one analog-to-digital converter chip into word alignment. The chip is clocked from the same 62.5 MHz master clock as the logic, so every lane runs at the same frequency. Each 14-bit sample travels double-data-rate at 875 Mb/s per lane. The deserializers and delay elements sit outside this block. The controller drives their shared delay tap and their bitslip inputs, and it watches the deserialized word from the frame-marker lane, which always carries a fixed pattern.

After a soft reset, the controller runs on its own. It first sweeps every delay tap in ascending order. A tap passes when the frame word stays constant for 16 cycles. The controller then loads the tap halfway between the first and last passing taps. Next it issues bitslip pulses, waiting 4 cycles after each one, until the frame word equals the expected pattern. It declares lock after 8 consecutive matching words.

The settings found on the frame lane are broadcast unchanged to every data lane. The data lane words are presented in the master clock domain, qualified by a valid flag, once lock is reached. If the sweep finds no usable tap, or no match appears within 14 slips, the controller raises an error and stops.

Top module: `lane_align_ctrl`

## Requirements
- R1: While and right after the soft reset, done, err and aligned_valid are 0, and tap_val and slip_total are 0.
- R2: The sweep loads every tap from 0 to 31 exactly once, in ascending order. Each tap gets one settle cycle, then the frame word is compared against the settle-cycle value for 16 cycles. The tap passes if the word never changes.
- R3: After the sweep, the controller loads tap floor((first passing + last passing)/2) once, before any bitslip pulse.
- R4: If no tap passes, err rises, no bitslip pulse is issued and tap_val stays at 31.
- R5: Bitslip pulses repeat until the frame word equals the pattern 14'h3F80 (bit 13 is the first bit). At least 4 cycles pass between a pulse or the final tap load and the next compare. slip_total counts the pulses issued.
- R6: If the word still differs after 14 pulses, err rises with slip_total equal to 14.
- R7: done rises only after 8 consecutive frame words equal the pattern. done and err are never both high.
- R8: Each tap load pulse and each bitslip pulse reaches all lanes in the same cycle: bit 0 is the frame lane and bits 1 to 7 are the data lanes.
- R9: aligned_words equals data_words delayed by one clock. aligned_valid is done delayed by one clock, and is 0 before lock.
- R10: Once done or err is high, it stays high until reset. tap_val does not change and no further pulses are issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 62.5 MHz master clock |
| rst | input | 1 | Synchronous soft reset, active high |
| frame_word | input | 14 | Deserialized word from the frame-marker lane |
| data_words | input | 98 | Deserialized words of the 7 data lanes, lane 0 in the low bits |
| tap_val | output | 5 | Delay tap value shared by all lanes |
| tap_ld | output | 8 | Per-lane tap load strobe (bit 0 = frame lane) |
| slip | output | 8 | Per-lane bitslip pulse (bit 0 = frame lane) |
| slip_total | output | 4 | Number of bitslip pulses issued since reset |
| aligned_words | output | 98 | Data lane words in the master clock domain |
| aligned_valid | output | 1 | aligned_words are framed and valid |
| done | output | 1 | Alignment complete |
| err | output | 1 | Alignment failed; controller stopped |

## Verification
A tap load or a bitslip pulse seen at a clock edge changes the modelled frame word for the cycle that follows. The bench model therefore updates its tap and slip state on that same edge, and the controller's settle and wait cycles absorb the change. The bench samples only on falling edges. Final tap, slip count and flags are read once done or err is seen. aligned_words is checked exactly one edge after a data word is driven. The hold checks look at tap_val and the pulse outputs for 20 cycles after completion.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_LOAD,
      ST_SETTLE,
      ST_CHECK,
      ST_EVAL,
      ST_APPLY,
      ST_WAIT,
      ST_CMP,
      ST_SLIP,
      ST_LOCK,
      ST_DONE,
      ST_ERR
   } la_state_e;
endpackage

// File: rtl/la_stable_det.sv
module la_stable_det #(
   parameter int WORD_W     = 14,
   parameter int STABLE_CYC = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              arm,
   input  logic              en,
   input  logic [WORD_W-1:0] word,
   output logic              pass,
   output logic              fail
);
   localparam int CW = $clog2(STABLE_CYC + 1);

   if (STABLE_CYC < 1) begin : g_bad_cyc
      $error("la_stable_det: STABLE_CYC must be at least 1");
   end

   logic [WORD_W-1:0] ref_q;
   logic [CW-1:0]     cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ref_q <= '0;
         cnt_q <= '0;
      end else if (arm) begin
         ref_q <= word;
         cnt_q <= '0;
      end else if (en) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_comb begin
      fail = en && (word != ref_q);
      pass = en && (word == ref_q) && (cnt_q == CW'(STABLE_CYC - 1));
   end

   // R2: a compare window never runs past its length
   a_r2_window_bound: assert property (@(posedge clk) disable iff (rst)
      en |-> (cnt_q < CW'(STABLE_CYC)));
endmodule

// File: rtl/la_lane_fanout.sv
module la_lane_fanout #(
   parameter int WORD_W     = 14,
   parameter int DATA_LANES = 7,
   parameter bit REG_OUT    = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         tap_ld_in,
   input  logic                         slip_in,
   input  logic                         done_in,
   input  logic [DATA_LANES*WORD_W-1:0] data_in,
   output logic [DATA_LANES:0]          tap_ld_out,
   output logic [DATA_LANES:0]          slip_out,
   output logic [DATA_LANES*WORD_W-1:0] data_out,
   output logic                         valid_out
);
   for (genvar g = 0; g <= DATA_LANES; g++) begin : g_lane
      assign tap_ld_out[g] = tap_ld_in;
      assign slip_out[g]   = slip_in;
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            data_out  <= '0;
            valid_out <= 1'b0;
         end else begin
            data_out  <= data_in;
            valid_out <= done_in;
         end
      end
      // R9: valid follows lock one clock later
      a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
         done_in |=> valid_out);
   end else begin : g_comb
      assign data_out  = data_in;
      assign valid_out = done_in;
   end
endmodule

// File: rtl/lane_align_ctrl.sv
module lane_align_ctrl
   import lane_align_pkg::*;
#(
   parameter int              WORD_W     = 14,
   parameter int              DATA_LANES = 7,
   parameter int              NUM_TAPS   = 32,
   parameter int              STABLE_CYC = 16,
   parameter int              SLIP_WAIT  = 4,
   parameter int              MAX_SLIP   = 14,
   parameter int              LOCK_WORDS = 8,
   parameter logic [WORD_W-1:0] FRAME_PAT = 14'h3F80,
   parameter bit              REG_OUT    = 1'b1,
   localparam int             TAP_W      = $clog2(NUM_TAPS),
   localparam int             SCW        = $clog2(MAX_SLIP + 1),
   localparam int             DW         = DATA_LANES * WORD_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [WORD_W-1:0] frame_word,
   input  logic [DW-1:0]     data_words,
   output logic [TAP_W-1:0]  tap_val,
   output logic [DATA_LANES:0] tap_ld,
   output logic [DATA_LANES:0] slip,
   output logic [SCW-1:0]    slip_total,
   output logic [DW-1:0]     aligned_words,
   output logic              aligned_valid,
   output logic              done,
   output logic              err
);
   localparam int WCW = $clog2(SLIP_WAIT + 1);
   localparam int LCW = $clog2(LOCK_WORDS + 1);
   localparam int GCW = $clog2(SLIP_WAIT + 2);
   localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(NUM_TAPS - 1);

   if (NUM_TAPS < 2 || (1 << TAP_W) != NUM_TAPS) begin : g_bad_taps
      $error("lane_align_ctrl: NUM_TAPS must be a power of two >= 2");
   end
   if (SLIP_WAIT < 1 || MAX_SLIP < 1) begin : g_bad_slip
      $error("lane_align_ctrl: SLIP_WAIT and MAX_SLIP must be >= 1");
   end
   if (LOCK_WORDS < 2) begin : g_bad_lock
      $error("lane_align_ctrl: LOCK_WORDS must be >= 2");
   end

   la_state_e        state_q;
   logic [TAP_W-1:0] first_q, last_q;
   logic             any_pass_q;
   logic [WCW-1:0]   wcnt_q;
   logic [LCW-1:0]   lcnt_q;
   logic [GCW-1:0]   since_slip_q;
   logic             det_pass, det_fail;
   logic             pat_hit;
   logic [TAP_W:0]   mid_sum;

   assign pat_hit = (frame_word == FRAME_PAT);
   assign mid_sum = {1'b0, first_q} + {1'b0, last_q};

   la_stable_det #(.WORD_W(WORD_W), .STABLE_CYC(STABLE_CYC)) u_det (
      .clk  (clk),
      .rst  (rst),
      .arm  (state_q == ST_SETTLE),
      .en   (state_q == ST_CHECK),
      .word (frame_word),
      .pass (det_pass),
      .fail (det_fail)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q    <= ST_IDLE;
         tap_val    <= '0;
         first_q    <= '0;
         last_q     <= '0;
         any_pass_q <= 1'b0;
         slip_total <= '0;
         wcnt_q     <= '0;
         lcnt_q     <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE:   state_q <= ST_LOAD;
            ST_LOAD:   state_q <= ST_SETTLE;
            ST_SETTLE: state_q <= ST_CHECK;
            ST_CHECK: begin
               if (det_pass || det_fail) begin
                  if (det_pass) begin
                     if (!any_pass_q) first_q <= tap_val;
                     last_q     <= tap_val;
                     any_pass_q <= 1'b1;
                  end
                  if (tap_val == LAST_TAP) begin
                     state_q <= ST_EVAL;
                  end else begin
                     tap_val <= tap_val + 1'b1;
                     state_q <= ST_LOAD;
                  end
               end
            end
            ST_EVAL: begin
               if (!any_pass_q) begin
                  state_q <= ST_ERR;
               end else begin
                  tap_val <= mid_sum[TAP_W:1];
                  state_q <= ST_APPLY;
               end
            end
            ST_APPLY: begin
               wcnt_q  <= '0;
               state_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (wcnt_q == WCW'(SLIP_WAIT - 1)) state_q <= ST_CMP;
               else wcnt_q <= wcnt_q + 1'b1;
            end
            ST_CMP: begin
               if (pat_hit) begin
                  lcnt_q  <= LCW'(1);
                  state_q <= ST_LOCK;
               end else if (slip_total == SCW'(MAX_SLIP)) begin
                  state_q <= ST_ERR;
               end else begin
                  state_q <= ST_SLIP;
               end
            end
            ST_SLIP: begin
               slip_total <= slip_total + 1'b1;
               wcnt_q     <= '0;
               state_q    <= ST_WAIT;
            end
            ST_LOCK: begin
               if (!pat_hit) state_q <= ST_CMP;
               else if (lcnt_q == LCW'(LOCK_WORDS - 1)) state_q <= ST_DONE;
               else lcnt_q <= lcnt_q + 1'b1;
            end
            ST_DONE:   state_q <= ST_DONE;
            ST_ERR:    state_q <= ST_ERR;
            default:   state_q <= ST_ERR;
         endcase
      end
   end

   // cycles since the last slip or tap load, saturating
   always_ff @(posedge clk) begin
      if (rst) since_slip_q <= GCW'(SLIP_WAIT + 1);
      else if (state_q == ST_SLIP || state_q == ST_APPLY) since_slip_q <= '0;
      else if (since_slip_q != GCW'(SLIP_WAIT + 1)) since_slip_q <= since_slip_q + 1'b1;
   end

   assign done = (state_q == ST_DONE);
   assign err  = (state_q == ST_ERR);

   la_lane_fanout #(.WORD_W(WORD_W), .DATA_LANES(DATA_LANES), .REG_OUT(REG_OUT)) u_fan (
      .clk        (clk),
      .rst        (rst),
      .tap_ld_in  (state_q == ST_LOAD || state_q == ST_APPLY),
      .slip_in    (state_q == ST_SLIP),
      .done_in    (done),
      .data_in    (data_words),
      .tap_ld_out (tap_ld),
      .slip_out   (slip),
      .data_out   (aligned_words),
      .valid_out  (aligned_valid)
   );

   // R5: a compare never happens before the wait after a slip or tap load
   a_r5_cmp_after_wait: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_CMP) |-> (since_slip_q >= GCW'(SLIP_WAIT)));
   // R6: no pulse beyond the slip limit
   a_r6_slip_bound: assert property (@(posedge clk) disable iff (rst)
      slip[0] |-> (slip_total < SCW'(MAX_SLIP)));
   // R4: an error stops all bitslip activity
   a_r4_err_quiet: assert property (@(posedge clk) disable iff (rst)
      err |-> (slip == '0) && (tap_ld == '0));
   // R7: flags are exclusive
   a_r7_flag_excl: assert property (@(posedge clk) disable iff (rst)
      !(done && err));
   // R10: completion is sticky and freezes the tap
   a_r10_done_hold: assert property (@(posedge clk) disable iff (rst)
      done |=> done && $stable(tap_val) && (slip == '0));
endmodule

// File: tb/lane_align_ctrl_tb_top.sv
module lane_align_ctrl_tb_top;
   localparam int W  = 14;
   localparam int DL = 7;
   localparam int DW = DL * W;
   localparam logic [W-1:0] PAT = 14'h3F80;

   // vector: lo[15:11] hi[10:6] off[5:2] mode[1:0]; mode 0 normal, 1 no good tap, 2 never match
   localparam logic [15:0] VEC [7] = '{
      {5'd8,  5'd20, 4'd0,  2'd0},
      {5'd0,  5'd31, 4'd5,  2'd0},
      {5'd3,  5'd3,  4'd13, 2'd0},
      {5'd25, 5'd31, 4'd1,  2'd0},
      {5'd10, 5'd13, 4'd7,  2'd0},
      {5'd31, 5'd0,  4'd0,  2'd1},
      {5'd4,  5'd9,  4'd2,  2'd2}
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [W-1:0]  frame_word;
   logic [DW-1:0] data_words = '0;
   logic [4:0]    tap_val;
   logic [DL:0]   tap_ld, slip;
   logic [3:0]    slip_total;
   logic [DW-1:0] aligned_words;
   logic          aligned_valid, done, err;

   int n_tests = 0;
   int n_fail  = 0;

   // channel model state
   logic [4:0] m_lo = 0, m_hi = 0;
   logic [3:0] m_off = 0;
   logic [1:0] m_mode = 0;
   logic [4:0] cur_tap;
   int slips_m, scan_idx, loads, post_pulses;
   logic order_bad, bcast_bad;
   logic [31:0] cyc = 0;

   always #2.5 clk = ~clk;

   lane_align_ctrl dut_i (
      .clk(clk), .rst(rst), .frame_word(frame_word), .data_words(data_words),
      .tap_val(tap_val), .tap_ld(tap_ld), .slip(slip), .slip_total(slip_total),
      .aligned_words(aligned_words), .aligned_valid(aligned_valid),
      .done(done), .err(err)
   );

   function automatic logic [W-1:0] rotl(input logic [W-1:0] w, input int n);
      logic [W-1:0] r = w;
      for (int i = 0; i < n; i++) r = {r[W-2:0], r[W-1]};
      return r;
   endfunction

   always_comb begin
      if (m_mode == 2'd1 || cur_tap < m_lo || cur_tap > m_hi)
         frame_word = cyc[0] ? PAT : ~PAT;
      else if (m_mode == 2'd2)
         frame_word = rotl(14'h0001, (int'(m_off) + slips_m) % W);
      else
         frame_word = rotl(PAT, (int'(m_off) + slips_m) % W);
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if ((tap_ld != '0 && tap_ld != '1) || (slip != '0 && slip != '1)) bcast_bad <= 1'b1;
      if (rst) begin
         cur_tap <= '0; slips_m <= 0; scan_idx <= 0; loads <= 0;
         post_pulses <= 0; order_bad <= 1'b0; bcast_bad <= 1'b0;
      end else begin
         if (tap_ld[0]) begin
            cur_tap <= tap_val;
            loads   <= loads + 1;
            if (scan_idx < 32) begin
               if (tap_val != 5'(scan_idx)) order_bad <= 1'b1;
               scan_idx <= scan_idx + 1;
            end
         end
         if (slip[0]) slips_m <= slips_m + 1;
         if ((done || err) && (tap_ld != '0 || slip != '0)) post_pulses <= post_pulses + 1;
      end
   end

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic wait_end(output bit ok);
      ok = 1'b0;
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         if (done || err) begin ok = 1'b1; break; end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      bit ok;
      // R1: reset state
      repeat (3) @(negedge clk);
      check(!done && !err && !aligned_valid, "R1 flags", {done, err, aligned_valid}, 0);
      check(tap_val == 0 && slip_total == 0, "R1 tap/slip", {tap_val, slip_total}, 0);

      foreach (VEC[k]) begin
         int lo, hi, off, md, exp_tap, exp_slip;
         lo = int'(VEC[k][15:11]); hi = int'(VEC[k][10:6]);
         off = int'(VEC[k][5:2]);  md = int'(VEC[k][1:0]);
         m_lo = VEC[k][15:11]; m_hi = VEC[k][10:6];
         m_off = VEC[k][5:2];  m_mode = VEC[k][1:0];
         do_reset();
         repeat (10) @(negedge clk);
         check(!aligned_valid, "R9 valid low before lock", aligned_valid, 0);
         wait_end(ok);
         check(ok, "R7 completion", ok, 1);
         check(!order_bad, "R2 sweep order", order_bad, 0);
         check(!bcast_bad, "R8 broadcast", bcast_bad, 0);
         if (md == 1) begin
            check(err && !done, "R4 err flag", {done, err}, 1);
            check(slip_total == 0 && slips_m == 0, "R4 no slip", slip_total, 0);
            check(tap_val == 31, "R4 tap", tap_val, 31);
            check(loads == 32, "R2 load count", loads, 32);
         end else begin
            exp_tap  = (lo + hi) / 2;
            exp_slip = (md == 2) ? 14 : (W - off) % W;
            check(tap_val == 5'(exp_tap), "R3 midpoint tap", tap_val, exp_tap);
            check(loads == 33, "R3 single apply", loads, 33);
            check(slip_total == 4'(exp_slip), md == 2 ? "R6 slip count" : "R5 slip count",
                  slip_total, exp_slip);
            check(slips_m == exp_slip, "R5 pulses seen", slips_m, exp_slip);
            if (md == 2) check(err && !done, "R6 err flag", {done, err}, 1);
            else         check(done && !err, "R7 done flag", {done, err}, 2);
         end
      end

      // R9 and R10 on a normal run
      m_lo = 5'd6; m_hi = 5'd17; m_off = 4'd3; m_mode = 2'd0;
      do_reset();
      wait_end(ok);
      check(done, "R7 done second run", done, 1);
      @(negedge clk);
      check(aligned_valid, "R9 valid after lock", aligned_valid, 1);
      for (int i = 0; i < 4; i++) begin
         logic [DW-1:0] v;
         v = DW'({$urandom, $urandom, $urandom, $urandom});
         data_words = v;
         @(negedge clk);
         check(aligned_words == v, "R9 one-clock data path", aligned_words[63:0], v[63:0]);
      end
      repeat (20) @(negedge clk);
      check(done && tap_val == 5'd11, "R10 hold tap", tap_val, 11);
      check(post_pulses == 0, "R10 no pulses after done", post_pulses, 0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule